// File: doc/BRIEF.md
# Recursive Frame-Averaging Memory Controller

This block suppresses uncorrelated noise in a video stream by blending every incoming pixel with the pixel at the same position in the previous frame. The previous frame sits in an external single-port SRAM with asynchronous read. For each pixel the controller reads the stored value in one clock cycle. In the next cycle it writes the blended value back to the same address. Two cycles of the block clock make one pixel period, so the block clock runs at twice the pixel rate. The blended pixel is also passed downstream as a stream, and it becomes valid in the same cycle as the write-back.

A frame-start pulse marks the first pixel of each frame and clears the pixel address counter. Until a second frame start has been seen after reset, the memory holds nothing meaningful. During that time each pixel is blended with itself, so it passes through unchanged and is stored as the seed.

Pixels enter and leave on valid/ready streams. A pixel is taken when `pix_in_valid` and `pix_in_ready` are both high at a clock edge. A result is taken when `pix_out_valid` and `pix_out_ready` are both high. The block drops `pix_in_ready` during every write slot. It also drops it while a result is waiting that downstream has not taken. A waiting result stays unchanged until downstream takes it.

Top module: `frame_avg_ctrl`

## Requirements
- R1: After reset, `pix_in_ready` is 1 while `pix_out_valid`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: A pixel accepted in the same cycle as `frame_start`, or as the first pixel after it, is read from and written to address 0.
- R3: Each accepted pixel moves the address on by one. The address wraps from 2^ADDR_W-1 back to 0 when no frame start intervenes.
- R4: `mem_rd_en` is high in the cycle a pixel is accepted, with `mem_addr` showing that pixel's address.
- R5: In the cycle after a read, `mem_wr_en` is high and `mem_addr` holds the same address.
- R6: The result is (stored + incoming) >> 1, computed with a 9-bit sum and truncated. For example, 255 and 254 give 254, and 1 and 0 give 0.
- R7: Before the second `frame_start` after reset, every result equals its incoming pixel.
- R8: `pix_out_valid` rises in the write-back cycle, and `pix_out_data` equals `mem_wdata`. While `pix_out_valid` is high and `pix_out_ready` is low, the data holds.
- R9: `mem_rd_en` and `mem_wr_en` are never high together. `pix_in_ready` is 0 during a write slot and while an untaken result waits.
- R10: With input always valid and output always ready, the block accepts exactly one pixel every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the first pixel of a frame |
| pix_in_valid | input | 1 | Incoming pixel valid |
| pix_in_ready | output | 1 | Block can take a pixel this cycle |
| pix_in_data | input | PIX_W | Current-frame pixel |
| pix_out_valid | output | 1 | Blended pixel valid |
| pix_out_ready | input | 1 | Downstream takes the blended pixel |
| pix_out_data | output | PIX_W | Blended pixel |
| mem_addr | output | ADDR_W | SRAM address |
| mem_rd_en | output | 1 | SRAM read strobe (read slot) |
| mem_wr_en | output | 1 | SRAM write strobe (write slot) |
| mem_wdata | output | PIX_W | SRAM write data |
| mem_rdata | input | PIX_W | SRAM asynchronous read data |

## Verification
Two things can land in the same cycle. One is a new pixel arriving. The other is either the write-back of the previous pixel or a result still waiting on a stalled output. The bench provokes this by holding input valid high while it toggles `pix_out_ready` at random and inserts stray frame-start pulses. A behavioural model predicts the outcome each cycle: it decides which slot owns the SRAM port, whether the new pixel is taken, and which address and data appear. A frame-start pulse that coincides with an accepted pixel is also judged, by checking that the pixel lands at address 0.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic {
    SLOT_READ  = 1'b0,
    SLOT_WRITE = 1'b1
  } slot_e;
endpackage

// File: rtl/fa_addr_gen.sv
module fa_addr_gen #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              step,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              use_mem
);
  logic [ADDR_W-1:0] cnt_q;
  logic              seen_q;
  logic              primed_q;

  // a sync in this cycle applies to the pixel taken in this cycle
  assign rd_addr = frame_start ? '0 : cnt_q;
  assign use_mem = primed_q || (frame_start && seen_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      seen_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      if (step)             cnt_q <= rd_addr + 1'b1;
      else if (frame_start) cnt_q <= '0;
      if (frame_start) begin
        seen_q <= 1'b1;
        if (seen_q) primed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fa_slot_ctrl.sv
module fa_slot_ctrl
  import fa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic accept,
  output logic wr_slot,
  output logic out_valid
);
  slot_e slot_q;
  logic  ov_q;

  assign in_ready  = (slot_q == SLOT_READ) && (!ov_q || out_ready);
  assign accept    = in_valid && in_ready;
  assign wr_slot   = (slot_q == SLOT_WRITE);
  assign out_valid = ov_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= SLOT_READ;
      ov_q   <= 1'b0;
    end else begin
      slot_q <= accept ? SLOT_WRITE : SLOT_READ;
      if (accept)                ov_q <= 1'b1;
      else if (ov_q && out_ready) ov_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fa_avg_unit.sv
module fa_avg_unit #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             use_mem,
  input  logic [PIX_W-1:0] cur_pix,
  input  logic [PIX_W-1:0] old_pix,
  output logic [PIX_W-1:0] avg_q
);
  localparam int SUM_W = PIX_W + 1;

  logic [PIX_W-1:0] prev;
  logic [SUM_W-1:0] sum;

  assign prev = use_mem ? old_pix : cur_pix;
  assign sum  = {1'b0, prev} + {1'b0, cur_pix};

  always_ff @(posedge clk) begin
    if (!rst_n)     avg_q <= '0;
    else if (load)  avg_q <= PIX_W'(sum >> 1);
  end
endmodule

// File: rtl/frame_avg_ctrl.sv
module frame_avg_ctrl #(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_in_valid,
  output logic              pix_in_ready,
  input  logic [PIX_W-1:0]  pix_in_data,
  output logic              pix_out_valid,
  input  logic              pix_out_ready,
  output logic [PIX_W-1:0]  pix_out_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata
);
  logic              accept;
  logic              wr_slot;
  logic              use_mem;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [PIX_W-1:0]  avg_q;

  fa_slot_ctrl u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_in_valid),
    .out_ready (pix_out_ready),
    .in_ready  (pix_in_ready),
    .accept    (accept),
    .wr_slot   (wr_slot),
    .out_valid (pix_out_valid)
  );

  fa_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .step        (accept),
    .rd_addr     (rd_addr),
    .use_mem     (use_mem)
  );

  fa_avg_unit #(.PIX_W(PIX_W)) u_avg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .use_mem (use_mem),
    .cur_pix (pix_in_data),
    .old_pix (mem_rdata),
    .avg_q   (avg_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      wr_addr_q <= '0;
    else if (accept) wr_addr_q <= rd_addr;
  end

  assign mem_rd_en    = accept;
  assign mem_wr_en    = wr_slot;
  assign mem_addr     = wr_slot ? wr_addr_q : rd_addr;
  assign mem_wdata    = avg_q;
  assign pix_out_data = avg_q;
endmodule

// File: rtl/frame_avg_chk.sv
module frame_avg_chk #(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_in_valid,
  input logic              pix_in_ready,
  input logic              pix_out_valid,
  input logic              pix_out_ready,
  input logic [PIX_W-1:0]  pix_out_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [PIX_W-1:0]  mem_wdata
);
  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  // R9
  no_take_in_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !pix_in_ready);
  // R4
  rd_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_in_valid && pix_in_ready) |-> mem_rd_en);
  // R5
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_wr_en && mem_addr == $past(mem_addr)));
  // R8
  out_eq_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (pix_out_valid && pix_out_data == mem_wdata));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready) |=> (pix_out_valid && $stable(pix_out_data)));
  // R10
  no_b2b_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind frame_avg_ctrl frame_avg_chk #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pix_in_valid  (pix_in_valid),
  .pix_in_ready  (pix_in_ready),
  .pix_out_valid (pix_out_valid),
  .pix_out_ready (pix_out_ready),
  .pix_out_data  (pix_out_data),
  .mem_addr      (mem_addr),
  .mem_rd_en     (mem_rd_en),
  .mem_wr_en     (mem_wr_en),
  .mem_wdata     (mem_wdata)
);

// File: tb/test_frame_avg_ctrl.sv
module test_frame_avg_ctrl;
  localparam int PW = 8;
  localparam int AW = 15;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [PW-1:0] in_pix = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [PW-1:0] out_data;
  logic [AW-1:0] mem_addr;
  logic rd_en, wr_en;
  logic [PW-1:0] wdata, rdata;

  always #5 clk = ~clk;

  frame_avg_ctrl #(.PIX_W(PW), .ADDR_W(AW)) i_frame_avg_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_in_valid(in_valid), .pix_in_ready(in_ready), .pix_in_data(in_pix),
    .pix_out_valid(out_valid), .pix_out_ready(out_ready), .pix_out_data(out_data),
    .mem_addr(mem_addr), .mem_rd_en(rd_en), .mem_wr_en(wr_en),
    .mem_wdata(wdata), .mem_rdata(rdata)
  );

  // external SRAM: asynchronous read, synchronous write
  logic [PW-1:0] sram [0:DEPTH-1];
  assign rdata = sram[mem_addr];
  always @(posedge clk) if (wr_en) sram[mem_addr] <= wdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int refimg [0:DEPTH-1];
  bit m_wr = 0, m_ov = 0, m_seen = 0, m_primed = 0;
  int m_addr = 0, m_wr_addr = 0, m_avg = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wr = 0; m_ov = 0; m_seen = 0; m_primed = 0;
      m_addr = 0; m_wr_addr = 0; m_avg = 0;
    end else begin
      bit rdy, take;
      int a, old;
      rdy  = !m_wr && (!m_ov || out_ready);
      take = in_valid && rdy;
      a    = frame_start ? 0 : m_addr;
      if (take) begin
        old = (m_primed || (frame_start && m_seen)) ? refimg[a] : int'(in_pix);
        m_avg = (old + int'(in_pix)) / 2;
        refimg[a] = m_avg;
        m_wr_addr = a;
        m_addr = (a + 1) % DEPTH;
      end else if (frame_start) m_addr = 0;
      if (frame_start) begin
        if (m_seen) m_primed = 1;
        m_seen = 1;
      end
      if (take) m_ov = 1;
      else if (m_ov && out_ready) m_ov = 0;
      m_wr = take;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit rdy;
      int ea;
      rdy = !m_wr && (!m_ov || out_ready);
      ea  = m_wr ? m_wr_addr : (frame_start ? 0 : m_addr);
      check(in_ready == rdy, "R9 in_ready", int'(in_ready), int'(rdy));
      check(rd_en == (in_valid && rdy), "R4 rd_en", int'(rd_en), int'(in_valid && rdy));
      check(wr_en == m_wr, "R5 wr_en", int'(wr_en), int'(m_wr));
      check(int'(mem_addr) == ea, m_wr ? "R5 addr" : "R3 addr", int'(mem_addr), ea);
      check(out_valid == m_ov, "R8 out_valid", int'(out_valid), int'(m_ov));
      if (m_ov) check(int'(out_data) == m_avg, "R6 out_data", int'(out_data), m_avg);
      if (m_wr) check(int'(wdata) == m_avg, "R6 wdata", int'(wdata), m_avg);
    end
  end

  task automatic push(input logic [PW-1:0] p, input bit fs,
                      output int res, output int a);
    while (!in_ready) begin @(posedge clk); #1; end
    in_valid = 1; in_pix = p; frame_start = fs;
    @(negedge clk); a = int'(mem_addr);
    @(posedge clk); #1;
    in_valid = 0; frame_start = 0;
    @(negedge clk); res = int'(out_data);
  endtask

  function automatic int f1val(input int i);
    case (i)
      0: return 255;
      1: return 1;
      2: return 100;
      default: return i * 17;
    endcase
  endfunction

  function automatic int f2val(input int i);
    case (i)
      0: return 254;
      1: return 0;
      2: return 51;
      default: return 200 - i;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin sram[i] = '0; refimg[i] = 0; end
  end

  initial begin
    int res, a, cnt;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(rd_en == 1'b0 && wr_en == 1'b0, "R1 strobes", int'(rd_en | wr_en), 0);
    rst_n = 1;
    @(posedge clk); #1;

    // frame 1: pass-through seeding
    for (int i = 0; i < 8; i++) begin
      push(PW'(f1val(i)), i == 0, res, a);
      if (i == 0) check(a == 0, "R2 first address", a, 0);
      check(res == f1val(i) % 256, "R7 pass-through", res, f1val(i) % 256);
    end
    // frame 2: averaging against frame 1
    for (int i = 0; i < 8; i++) begin
      int e;
      push(PW'(f2val(i)), i == 0, res, a);
      e = ((f1val(i) % 256) + f2val(i)) >> 1;
      check(a == i, "R3 address step", a, i);
      check(res == e, "R6 average", res, e);
    end

    // back-pressure: result waits, input blocked
    @(posedge clk); #1;
    out_ready = 0;
    push(8'd77, 1'b0, res, a);
    in_valid = 1; in_pix = 8'd9;
    repeat (4) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R9 stall in_ready", int'(in_ready), 0);
      check(out_valid == 1'b1 && int'(out_data) == m_avg, "R8 hold", int'(out_data), m_avg);
    end
    #1; out_ready = 1;
    @(posedge clk); #1; in_valid = 0;
    repeat (2) @(posedge clk); #1;

    // R10 throughput
    cnt = 0;
    in_valid = 1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (in_ready) cnt++;
      @(posedge clk); #1;
      in_pix = PW'(c * 7);
    end
    in_valid = 0;
    check(cnt == 20, "R10 accept rate", cnt, 20);
    @(posedge clk); #1;

    // random mix of stalls, stray syncs and gaps
    for (int c = 0; c < 400; c++) begin
      in_valid = ($urandom % 4) != 0;
      in_pix = PW'($urandom);
      out_ready = ($urandom % 3) != 0;
      frame_start = ($urandom % 50) == 0;
      @(posedge clk); #1;
    end
    in_valid = 0; frame_start = 0; out_ready = 1;
    repeat (3) @(posedge clk); #1;

    // full-depth frame then wrap
    push(8'd5, 1'b1, res, a);
    check(a == 0, "R2 sync address", a, 0);
    for (int i = 1; i < DEPTH; i++) push(PW'(i), 1'b0, res, a);
    check(a == DEPTH - 1, "R3 last address", a, DEPTH - 1);
    push(8'd33, 1'b0, res, a);
    check(a == 0, "R3 wrap", a, 0);

    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule